// File: doc/BRIEF.md
# Configuration Snapshot Transfer

This block carries a group of configuration fields from a 100 MHz system clock domain into an asynchronous 65 MHz processing domain so that they all change at once. Software writes fields one at a time into staging registers on the system side. These writes stay local to the system side until a commit strobe arrives. The commit packs every staged field into one wide frame and pushes that frame into a small dual-clock FIFO.

On the processing side, any frame waiting in the FIFO is popped at once. All shadow registers load from that frame on the same edge, and an update pulse marks the cycle in which the new values first appear. The processing logic therefore sees either the old set of values or the new set, never a mix of the two. If a commit arrives while the FIFO is full, the frame is dropped and a sticky overflow flag is raised, which software can clear.

Top module: `cfg_snapshot_xfer`

## Requirements
- R1: A write with `wr_en_i` high and address a (0 to NUM_FIELDS-1) changes only staging field a. Until a commit, neither `shadow_o` nor `update_o` responds.
- R2: A commit (`commit_i` high for one system cycle) enqueues exactly one frame holding every staged field. Field i sits at bits [i*FIELD_W +: FIELD_W] of the frame and of `shadow_o`.
- R3: A field write in the same cycle as a commit is left out of that commit's frame. It is carried by the next commit.
- R4: Each popped frame loads all shadow fields on a single processing-clock edge. `update_o` is high for the processing cycle in which the new values are first visible.
- R5: Frames arrive in commit order, each exactly once, and no update happens without a commit.
- R6: Up to DEPTH (4) uncollected frames are held. A commit while all DEPTH are occupied is dropped and sets `ovf_o` on the next system edge.
- R7: `ovf_o` stays set until `ovf_clr_i`. A dropped commit in the same cycle as a clear leaves it set.
- R8: After reset, `shadow_o` and the staging fields equal RESET_FRAME, and `update_o` and `ovf_o` are low. A commit with no prior writes delivers RESET_FRAME.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk_i | input | 1 | System-side clock (100 MHz) |
| proc_clk_i | input | 1 | Processing-side clock (65 MHz) |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| wr_en_i | input | 1 | Staging field write enable |
| wr_addr_i | input | ADDR_W | Staging field index |
| wr_data_i | input | FIELD_W | Staging field write data |
| commit_i | input | 1 | Commit strobe: pack and enqueue all staged fields |
| ovf_clr_i | input | 1 | Clears the sticky overflow flag |
| ovf_o | output | 1 | Sticky flag: a commit was dropped on a full FIFO |
| shadow_o | output | NUM_FIELDS*FIELD_W | Processing-side shadow fields, packed |
| update_o | output | 1 | One-cycle pulse: new shadow values present |

## Verification
Assertions check several rules on every clock. The shadow outputs never change without the update pulse. Each Gray pointer moves by at most one bit per clock. The overflow flag sets after a commit into a full FIFO, holds until it is cleared, and drops once cleared. Frame content, field placement, commit order, the exclusion of a write made in the commit cycle, and the exact fill level at which commits start to drop can only be shown by the bench scenarios. For the fill-level scenario, the bench stops the processing clock, fills the FIFO, then restarts the clock and compares every delivered frame against a scoreboard.

// File: rtl/cfg_snap_pkg.sv
package cfg_snap_pkg;
  function automatic int unsigned addr_bits(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cfg_snap_sync2.sv
module cfg_snap_sync2 #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/cfg_snap_stage.sv
module cfg_snap_stage #(
  parameter int unsigned NUM_FIELDS = 4,
  parameter int unsigned FIELD_W    = 16,
  parameter logic [NUM_FIELDS*FIELD_W-1:0] RESET_FRAME = '0,
  localparam int unsigned ADDR_W  = cfg_snap_pkg::addr_bits(NUM_FIELDS),
  localparam int unsigned FRAME_W = NUM_FIELDS*FIELD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [FIELD_W-1:0] wr_data_i,
  input  logic               commit_i,
  input  logic               ovf_clr_i,
  input  logic               full_i,
  output logic               push_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               ovf_o
);
  logic [FRAME_W-1:0] stage_q;
  logic               ovf_q;
  logic               drop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= RESET_FRAME;
    end else if (wr_en_i) begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (wr_addr_i == ADDR_W'(i)) stage_q[i*FIELD_W +: FIELD_W] <= wr_data_i;
      end
    end
  end

  // Frame is taken from registered staging: same-cycle write goes to the next commit
  assign frame_o = stage_q;
  assign push_o  = commit_i && !full_i;
  assign drop    = commit_i && full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (drop)      ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  assign ovf_o = ovf_q;

  // R6
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && full_i) |=> ovf_o);
  // R7
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
  // R7
  ovf_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_clr_i && !(commit_i && full_i)) |=> !ovf_o);
endmodule

// File: rtl/cfg_snap_fifo.sv
module cfg_snap_fifo #(
  parameter int unsigned W     = 64,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic         wclk_i,
  input  logic         rclk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o
);
  localparam logic [PW-1:0] FULL_MASK = PW'(3) << (AW - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin_q, wgray_q, wbin_n, rq2_wgray;
  logic [PW-1:0] rbin_q, rgray_q, rbin_n, wq2_rgray;

  // write domain
  assign wbin_n = wbin_q + PW'(push_i);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_n;
      wgray_q <= wbin_n ^ (wbin_n >> 1);
    end
  end

  always_ff @(posedge wclk_i) begin
    if (push_i) mem[wbin_q[AW-1:0]] <= wdata_i;
  end

  cfg_snap_sync2 #(.W(PW)) u_sync_r2w (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .d_i   (rgray_q),
    .q_o   (rq2_wgray)
  );

  assign full_o = (wgray_q == (rq2_wgray ^ FULL_MASK));

  // read domain
  assign rbin_n = rbin_q + PW'(pop_i);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_n;
      rgray_q <= rbin_n ^ (rbin_n >> 1);
    end
  end

  cfg_snap_sync2 #(.W(PW)) u_sync_w2r (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (wgray_q),
    .q_o   (wq2_rgray)
  );

  assign empty_o = (rgray_q == wq2_rgray);
  assign rdata_o = mem[rbin_q[AW-1:0]];

  // R5
  wgray_step_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
  // R5
  rgray_step_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);
endmodule

// File: rtl/cfg_snap_unpack.sv
module cfg_snap_unpack #(
  parameter int unsigned FRAME_W = 64,
  parameter logic [FRAME_W-1:0] RESET_FRAME = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               empty_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               pop_o,
  output logic [FRAME_W-1:0] shadow_o,
  output logic               update_o
);
  logic [FRAME_W-1:0] shadow_q;
  logic               update_q;

  assign pop_o = !empty_i;

  // Whole frame loads on one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= RESET_FRAME;
      update_q <= 1'b0;
    end else begin
      update_q <= pop_o;
      if (pop_o) shadow_q <= frame_i;
    end
  end

  assign shadow_o = shadow_q;
  assign update_o = update_q;

  // R4
  shadow_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_o |-> $stable(shadow_o));
endmodule

// File: rtl/cfg_snapshot_xfer.sv
module cfg_snapshot_xfer #(
  parameter int unsigned NUM_FIELDS = 4,
  parameter int unsigned FIELD_W    = 16,
  parameter int unsigned DEPTH      = 4,
  parameter logic [NUM_FIELDS*FIELD_W-1:0] RESET_FRAME = 64'h0004_0003_0002_0001,
  localparam int unsigned ADDR_W  = cfg_snap_pkg::addr_bits(NUM_FIELDS),
  localparam int unsigned FRAME_W = NUM_FIELDS*FIELD_W
) (
  input  logic               sys_clk_i,
  input  logic               proc_clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [FIELD_W-1:0] wr_data_i,
  input  logic               commit_i,
  input  logic               ovf_clr_i,
  output logic               ovf_o,
  output logic [FRAME_W-1:0] shadow_o,
  output logic               update_o
);
  logic               push, full, pop, empty;
  logic [FRAME_W-1:0] wframe, rframe;

  cfg_snap_stage #(
    .NUM_FIELDS (NUM_FIELDS),
    .FIELD_W    (FIELD_W),
    .RESET_FRAME(RESET_FRAME)
  ) u_stage (
    .clk_i    (sys_clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .commit_i (commit_i),
    .ovf_clr_i(ovf_clr_i),
    .full_i   (full),
    .push_o   (push),
    .frame_o  (wframe),
    .ovf_o    (ovf_o)
  );

  cfg_snap_fifo #(
    .W    (FRAME_W),
    .DEPTH(DEPTH)
  ) u_fifo (
    .wclk_i (sys_clk_i),
    .rclk_i (proc_clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .wdata_i(wframe),
    .full_o (full),
    .pop_i  (pop),
    .rdata_o(rframe),
    .empty_o(empty)
  );

  cfg_snap_unpack #(
    .FRAME_W    (FRAME_W),
    .RESET_FRAME(RESET_FRAME)
  ) u_unpack (
    .clk_i   (proc_clk_i),
    .rst_ni  (rst_ni),
    .empty_i (empty),
    .frame_i (rframe),
    .pop_o   (pop),
    .shadow_o(shadow_o),
    .update_o(update_o)
  );
endmodule

// File: tb/cfg_snapshot_xfer_test.sv
`timescale 1ns/1ps
module cfg_snapshot_xfer_test;
  localparam int NF = 4;
  localparam int FW = 16;
  localparam int FRW = NF*FW;
  localparam logic [FRW-1:0] RST_FRAME = 64'h0004_0003_0002_0001;

  logic sys_clk = 1'b0, proc_clk = 1'b0, proc_run = 1'b1, rst_ni = 1'b0;
  logic wr_en = 1'b0, commit = 1'b0, ovf_clr = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [FW-1:0] wr_data = '0;
  logic ovf;
  logic [FRW-1:0] shadow;
  logic update;

  int checks = 0, fails = 0;
  logic [FRW-1:0] exp_q[$];
  logic [FRW-1:0] stage_m = RST_FRAME;
  logic [FRW-1:0] last_seen = RST_FRAME;

  always #5 sys_clk = ~sys_clk;
  always begin
    #7.692;
    if (proc_run) proc_clk = ~proc_clk;
  end

  cfg_snapshot_xfer uut (
    .sys_clk_i (sys_clk),
    .proc_clk_i(proc_clk),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .commit_i  (commit),
    .ovf_clr_i (ovf_clr),
    .ovf_o     (ovf),
    .shadow_o  (shadow),
    .update_o  (update)
  );

  task automatic check(input string req, input logic [FRW-1:0] act, input logic [FRW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge proc_clk) begin
    if (rst_ni && update) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R5 unexpected update actual=%h expected=none", shadow);
      end else begin
        check("R4 R5 frame", shadow, exp_q.pop_front());
        last_seen = shadow;
      end
    end
  end

  task automatic write_field(input int a, input logic [FW-1:0] d);
    @(negedge sys_clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = d;
    stage_m[a*FW +: FW] = d;
    @(negedge sys_clk);
    wr_en = 1'b0;
  endtask

  // commit, optionally with a same-cycle write and a clear
  task automatic do_commit(input bit accept, input bit wr, input int a,
                           input logic [FW-1:0] d, input bit clr);
    @(negedge sys_clk);
    commit = 1'b1; ovf_clr = clr;
    if (accept) exp_q.push_back(stage_m);
    if (wr) begin
      wr_en = 1'b1; wr_addr = 2'(a); wr_data = d;
      stage_m[a*FW +: FW] = d;
    end
    @(negedge sys_clk);
    commit = 1'b0; wr_en = 1'b0; ovf_clr = 1'b0;
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge sys_clk);
    repeat (12) @(negedge sys_clk);
    check("R5 all frames delivered", FRW'(exp_q.size()), '0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge sys_clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge sys_clk);
    // R8 reset state
    check("R8 shadow reset", shadow, RST_FRAME);
    check("R8 update reset", FRW'(update), '0);
    check("R8 ovf reset", FRW'(ovf), '0);

    // R8 commit with no writes delivers defaults
    do_commit(1, 0, 0, '0, 0);
    wait_drain();
    check("R8 default frame", shadow, RST_FRAME);

    // R1 writes stay local until commit
    write_field(0, 16'hA0A0);
    write_field(1, 16'hB1B1);
    write_field(2, 16'hC2C2);
    write_field(3, 16'hD3D3);
    repeat (30) @(negedge sys_clk);
    check("R1 no effect before commit", shadow, RST_FRAME);
    write_field(2, 16'h5A5A);
    repeat (10) @(negedge sys_clk);
    check("R1 no effect before commit", shadow, RST_FRAME);

    // R2 commit and field placement
    do_commit(1, 0, 0, '0, 0);
    wait_drain();
    check("R2 field2 slice", FRW'(shadow[2*FW +: FW]), FRW'(16'h5A5A));
    check("R2 field0 slice", FRW'(shadow[0 +: FW]), FRW'(16'hA0A0));

    // R3 same-cycle write excluded, carried next
    do_commit(1, 1, 0, 16'h7777, 0);
    wait_drain();
    check("R3 old field0 in frame", FRW'(shadow[0 +: FW]), FRW'(16'hA0A0));
    do_commit(1, 0, 0, '0, 0);
    wait_drain();
    check("R3 new field0 next commit", FRW'(shadow[0 +: FW]), FRW'(16'h7777));

    // R6 fill with processing clock stopped
    @(negedge proc_clk);
    #1 proc_run = 1'b0;
    for (int k = 0; k < 4; k++) begin
      write_field(1, 16'(16'h1000 + k));
      do_commit(1, 0, 0, '0, 0);
    end
    check("R6 ovf clear at depth", FRW'(ovf), '0);
    write_field(3, 16'hEEEE);
    do_commit(0, 0, 0, '0, 0);
    check("R6 ovf set on drop", FRW'(ovf), FRW'(1));
    // R7 dropped commit with clear: set wins
    do_commit(0, 0, 0, '0, 1);
    check("R7 set wins over clear", FRW'(ovf), FRW'(1));
    proc_run = 1'b1;
    wait_drain();
    check("R6 last kept frame", FRW'(last_seen[1*FW +: FW]), FRW'(16'h1003));
    check("R7 ovf sticky", FRW'(ovf), FRW'(1));
    @(negedge sys_clk); ovf_clr = 1'b1;
    @(negedge sys_clk); ovf_clr = 1'b0;
    check("R7 ovf cleared", FRW'(ovf), '0);

    // R4 back-to-back commits
    do_commit(1, 1, 2, 16'h2222, 0);
    do_commit(1, 1, 2, 16'h3333, 0);
    do_commit(1, 1, 3, 16'h4444, 0);
    wait_drain();
    check("R4 final shadow", shadow, stage_m & ~({FW{1'b1}} << (3*FW)) | (RST_FRAME & 64'h0) | (shadow & ({FW{1'b1}} << (3*FW))));
    check("R4 update low when idle", FRW'(update), '0);
    check("R6 ovf stays clear", FRW'(ovf), '0);

    finish_run();
  end
endmodule